// File: doc/BRIEF.md
# Millisecond Clock with Dual Interrupts

This block is a real-time clock peripheral for a small processor. A prescaler divides the system clock down to a one-millisecond tick. Each tick advances a 16-bit millisecond counter. The counter runs from 0 up to one minute's worth of counts and then restarts at zero. It does not wrap at a power of two.

The block has two interrupt sources. A short-interval source fires every 32 counts. A long-interval source fires once a minute. Each source has its own 4-bit priority level. A request appears as a single-cycle pulse on the bit of a level vector that matches the configured level.

A read port returns the current count. While the device is disabled, several things change:

- the clock stops;
- no requests are raised;
- a read is flagged as illegal;
- the caller's data passes through unchanged.

Top module: `msclk_rtc`

## Requirements
- R1: While `rst_n` is low and directly after it rises, the count is 0 and `irq_req` is all zeros.
- R2: The count advances by exactly one on every DIV-th clock cycle in which `enable` is high. The prescaler phase is counted from reset.
- R3: When the count after an advance is a multiple of FAST (default 32), a short-interval request is raised.
- R4: When an advance would reach WRAP (default 60000), the count becomes 0 and a long-interval request is raised.
- R5: The advance that wraps the count raises both requests in the same cycle. If both levels are equal, only that one bit is set.
- R6: A request is a one-cycle pulse on `irq_req[L]`, where L is the 4-bit level of its source. The pulse appears in the cycle after the advance, together with the new count.
- R7: With `enable` high, `rd_data` shows the count. A read in the same cycle as an advance returns the value from before that advance.
- R8: With `enable` low, the count and prescaler hold and `irq_req` stays zero. Also, `rd_illegal` equals `rd_en` and `rd_data` equals `rd_pass`.
- R9: The level fields are used only at the clock edge of an advance. Changing them at any other time does not alter which bit pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Device enable |
| lvl_fast | input | 4 | Priority level of the short-interval request |
| lvl_min | input | 4 | Priority level of the one-minute request |
| rd_en | input | 1 | Read instruction strobe |
| rd_pass | input | 16 | Data path value passed through when disabled |
| rd_data | output | 16 | Read result |
| rd_illegal | output | 1 | Read attempted while disabled |
| irq_req | output | 16 | Per-level request pulses |

## Verification
The bench builds the block with DIV=3, WRAP=96 and FAST=32. At those values a full minute takes only a few hundred cycles, and the wrap is reached many times in one run. Each wrap coincides with a short-interval multiple, so the shared-cycle and equal-level cases come up repeatedly. The small divisor also makes reads that land on an advance common. Random enable gaps and level changes between ticks cover the hold and sampling rules.

// File: rtl/msclk_rtc.sv
module msclk_rtc #(
  parameter int DIV  = 50000,
  parameter int WRAP = 60000,
  parameter int FAST = 32,
  parameter int CW   = 16,
  parameter int LW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [LW-1:0]       lvl_fast,
  input  logic [LW-1:0]       lvl_min,
  input  logic                rd_en,
  input  logic [CW-1:0]       rd_pass,
  output logic [CW-1:0]       rd_data,
  output logic                rd_illegal,
  output logic [(1<<LW)-1:0]  irq_req
);
  localparam int NL = 1 << LW;
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW = (FAST > 1) ? $clog2(FAST) : 1;

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fph;
  logic [CW-1:0] nxt;
  logic          tick, wrap, fast_hit;

  assign tick     = enable && (pre == PW'(DIV - 1));
  assign nxt      = cnt + 1'b1;
  assign wrap     = (nxt == CW'(WRAP));
  assign fast_hit = (fph == FW'(FAST - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= '0;
      fph     <= '0;
      irq_req <= '0;
    end else begin
      irq_req <= '0;
      if (enable) pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        cnt     <= wrap ? '0 : nxt;
        fph     <= (fast_hit || wrap) ? '0 : fph + 1'b1;
        irq_req <= (fast_hit ? (NL'(1) << lvl_fast) : '0)
                 | (wrap     ? (NL'(1) << lvl_min)  : '0);
      end
    end
  end

  assign rd_data    = enable ? cnt : rd_pass;
  assign rd_illegal = rd_en && !enable;
endmodule

module msclk_rtc_chk #(
  parameter int WRAP = 60000,
  parameter int FAST = 32,
  parameter int CW   = 16,
  parameter int LW   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [CW-1:0]       count,
  input logic [(1<<LW)-1:0]  irq_req
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  assert_fast_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req != '0) |-> (int'(count) % FAST == 0));

  assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) < WRAP);

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(WRAP - 1) && enable) |=> (count == CW'(WRAP - 1) || count == '0));

  assert_pulse_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_req) <= 2);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count));

  assert_quiet_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (irq_req == '0));
endmodule

bind msclk_rtc msclk_rtc_chk #(.WRAP(WRAP), .FAST(FAST), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .count(cnt), .irq_req(irq_req)
);

// File: tb/tb_msclk_rtc.sv
module tb_msclk_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 3;
  localparam int WRAP = 96;
  localparam int FAST = 32;
  localparam int CW   = 16;
  localparam int LW   = 4;
  localparam int NL   = 1 << LW;

  logic clk = 1'b0;
  logic rst_n, enable, rd_en, rd_illegal;
  logic [LW-1:0] lvl_fast, lvl_min;
  logic [CW-1:0] rd_pass, rd_data;
  logic [NL-1:0] irq_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msclk_rtc #(.DIV(DIV), .WRAP(WRAP), .FAST(FAST), .CW(CW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lvl_fast(lvl_fast), .lvl_min(lvl_min),
    .rd_en(rd_en), .rd_pass(rd_pass), .rd_data(rd_data), .rd_illegal(rd_illegal),
    .irq_req(irq_req)
  );

  // Reference model derived from the requirements
  int m_cnt, m_ph;
  logic [NL-1:0] m_req;
  logic m_adv;

  function automatic logic [NL-1:0] lvl_bit(input logic [LW-1:0] l);
    return NL'(1) << l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ph <= 0; m_req <= '0; m_adv <= 1'b0;
    end else begin
      m_req <= '0;
      m_adv <= 1'b0;
      if (enable) begin
        if (m_ph == DIV - 1) begin
          int n;
          logic [NL-1:0] r;
          n = m_cnt + 1;
          r = '0;
          if (n % FAST == 0) r = r | lvl_bit(lvl_fast);
          if (n == WRAP) begin
            r = r | lvl_bit(lvl_min);
            n = 0;
          end
          m_cnt <= n; m_ph <= 0; m_req <= r; m_adv <= 1'b1;
        end else begin
          m_ph <= m_ph + 1;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_cycle();
    string rq;
    if (!enable) begin
      check("R8 rd_data pass", 32'(rd_data), 32'(rd_pass));
      check("R8 rd_illegal", 32'(rd_illegal), 32'(rd_en));
    end else begin
      rq = (m_ph == DIV - 1 && rd_en) ? "R7 read on advance" : "R7 read";
      check(rq, 32'(rd_data), 32'(m_cnt));
      check("R7 rd_illegal", 32'(rd_illegal), 32'd0);
    end
    if (m_req != '0 && m_cnt == 0) rq = "R5 wrap requests";
    else if (m_req != '0) rq = "R3 R6 R9 fast request";
    else if (m_adv) rq = "R2 advance quiet";
    else rq = "R8 R6 no request";
    check(rq, 32'(irq_req), 32'(m_req));
    if (m_adv && m_cnt == 0) check("R4 wrap to zero", 32'(rd_data), 32'(enable ? 0 : rd_pass));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; enable = 1'b1; rd_en = 1'b1; rd_pass = 16'hBEEF;
    lvl_fast = 4'd5; lvl_min = 4'd9;
    repeat (4) @(negedge clk);
    check("R1 reset count", 32'(rd_data), 32'd0);
    check("R1 reset irq", 32'(irq_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'(rd_data), 32'd0);
    // directed: steady run, distinct levels
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      check_cycle();
      rd_en = 1'($urandom_range(0, 1));
      rd_pass = 16'($urandom);
    end
    // random: enable gaps, levels changing every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check_cycle();
      enable   = ($urandom_range(0, 9) != 0);
      lvl_fast = 4'($urandom);
      lvl_min  = 4'($urandom);
      rd_en    = 1'($urandom_range(0, 1));
      rd_pass  = 16'($urandom);
    end
    // directed: equal levels across several wraps
    enable = 1'b1; lvl_fast = 4'd7; lvl_min = 4'd7;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      check_cycle();
      rd_en = 1'($urandom_range(0, 1));
    end
    // directed: long disabled stretch
    enable = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      check_cycle();
      rd_en = 1'($urandom_range(0, 1));
      rd_pass = 16'($urandom);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule